// File: doc/BRIEF.md
# Seven-Step Irregular-Order State Counter

This block is a synchronous three-bit counter that steps through a fixed, non-binary cycle of seven codes: 0, 3, 2, 1, 5, 4, 7, and then back to 0. It takes one step on each rising clock edge where the count enable is high. The current code appears on a three-bit output. A wrap flag marks the last step of each cycle, so a neighbouring block can count whole cycles or trigger on the sequence boundary.

Code 6 is not part of the cycle. If the register ever holds 6, the next enabled edge moves it to 0, so the counter cannot lock up outside its cycle. A load port can place any code, including 6, into the register. This lets a test drive the counter into the unused code, and it lets surrounding logic start the cycle at a chosen point.

Top module: `custom_seq_counter`

## Requirements
- R1: While `rst` is high at a rising edge, `code` becomes 0 after that edge, whatever the other inputs are.
- R2: With `rst` and `load_en` low and `cnt_en` high, each edge moves `code` along the cycle 0→3→2→1→5→4→7. Each successor is the next entry in that list.
- R3: With `rst` and `load_en` low and `cnt_en` high, code 7 moves to code 0, so a full cycle is seven enabled edges.
- R4: With `rst`, `load_en` and `cnt_en` all low, `code` keeps its value across the edge. This also holds for code 6.
- R5: With `rst` and `load_en` low and `cnt_en` high, code 6 moves to code 0 in one edge.
- R6: `wrap` is high exactly when `code` is 7 and `cnt_en` is high. It is a combinational output and is low in every other case.
- R7: With `rst` low and `load_en` high, `code` takes the value of `load_code` after the edge, whatever `cnt_en` is.
- R8: Reset has priority over load, and load has priority over counting. With `rst` and `load_en` both high, `code` becomes 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count enable; one cycle step per enabled edge |
| load_en | input | 1 | Synchronous load of `load_code` |
| load_code | input | 3 | Code to load; any value, including the unused code 6 |
| code | output | 3 | Current state code |
| wrap | output | 1 | High while the state is 7 and counting is enabled |

## Verification
The embedded assertions check the following on every cycle:
- the reset result and its priority over load;
- the load result;
- holding when the counter is idle;
- several fixed successor pairs of the cycle, including the 7-to-0 wrap;
- recovery from code 6;
- that code 6 can only appear right after a load.

Only the bench's scenarios can show the following:
- the whole seven-code order repeated over several uninterrupted cycles;
- a cycle interleaved with idle gaps that still resumes at the right code;
- a deliberate load into code 6, followed by an idle hold and then recovery.

// File: rtl/seqc_pkg.sv
package seqc_pkg;

    localparam int CODE_W   = 3;
    localparam int N_CODES  = 1 << CODE_W;
    localparam int CYCLE_LEN = 7;

    typedef logic [CODE_W-1:0] code_t;

    typedef enum logic [CODE_W-1:0] {
        ST_A = 3'd0,
        ST_B = 3'd3,
        ST_C = 3'd2,
        ST_D = 3'd1,
        ST_E = 3'd5,
        ST_F = 3'd4,
        ST_G = 3'd7,
        ST_X = 3'd6
    } seq_state_e;

    typedef enum logic [1:0] {
        ACT_RESET,
        ACT_LOAD,
        ACT_STEP,
        ACT_HOLD
    } action_e;

    typedef struct packed {
        action_e act;
        code_t   load_val;
    } ctrl_t;

    function automatic seq_state_e succ(input seq_state_e s);
        case (s)
            ST_A:    return ST_B;
            ST_B:    return ST_C;
            ST_C:    return ST_D;
            ST_D:    return ST_E;
            ST_E:    return ST_F;
            ST_F:    return ST_G;
            ST_G:    return ST_A;
            default: return ST_A;
        endcase
    endfunction

    function automatic action_e pick_action(input logic rst, input logic ld, input logic en);
        if (rst)      return ACT_RESET;
        else if (ld)  return ACT_LOAD;
        else if (en)  return ACT_STEP;
        else          return ACT_HOLD;
    endfunction

endpackage

// File: rtl/seqc_ctrl.sv
module seqc_ctrl
    import seqc_pkg::*;
(
    input  logic  rst,
    input  logic  cnt_en,
    input  logic  load_en,
    input  code_t load_code,
    output ctrl_t ctrl
);

    always_comb begin
        ctrl.act      = pick_action(rst, load_en, cnt_en);
        ctrl.load_val = load_code;
    end

endmodule

// File: rtl/seqc_next.sv
module seqc_next
    import seqc_pkg::*;
(
    input  code_t cur,
    input  ctrl_t ctrl,
    output code_t nxt
);

    seq_state_e cur_s;

    always_comb begin
        cur_s = seq_state_e'(cur);
        unique case (ctrl.act)
            ACT_RESET: nxt = code_t'(ST_A);
            ACT_LOAD:  nxt = ctrl.load_val;
            ACT_STEP:  nxt = code_t'(succ(cur_s));
            default:   nxt = cur;
        endcase
    end

endmodule

// File: rtl/seqc_reg.sv
module seqc_reg
    import seqc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load_en,
    input  logic  cnt_en,
    input  code_t load_code,
    input  code_t d,
    output code_t q
);

    always_ff @(posedge clk) begin
        q <= d;
    end

    // R1 / R8: reset wins over everything
    a_r1_reset_zero: assert property (@(posedge clk) rst |=> (q == 3'd0));
    a_r8_reset_over_load: assert property (@(posedge clk) (rst && load_en) |=> (q == 3'd0));
    // R7: load
    a_r7_load_value: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (q == $past(load_code)));
    // R4: idle hold
    a_r4_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!load_en && !cnt_en) |=> $stable(q));

endmodule

// File: rtl/custom_seq_counter.sv
module custom_seq_counter
    import seqc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cnt_en,
    input  logic       load_en,
    input  logic [2:0] load_code,
    output logic [2:0] code,
    output logic       wrap
);

    ctrl_t ctrl;
    code_t nxt;
    code_t q;

    seqc_ctrl u_ctrl (
        .rst       (rst),
        .cnt_en    (cnt_en),
        .load_en   (load_en),
        .load_code (load_code),
        .ctrl      (ctrl)
    );

    seqc_next u_next (
        .cur  (q),
        .ctrl (ctrl),
        .nxt  (nxt)
    );

    seqc_reg u_reg (
        .clk       (clk),
        .rst       (rst),
        .load_en   (load_en),
        .cnt_en    (cnt_en),
        .load_code (load_code),
        .d         (nxt),
        .q         (q)
    );

    assign code = q;
    assign wrap = cnt_en && (q == code_t'(ST_G));

    // R2: fixed successor pairs of the irregular order
    a_r2_zero_to_three: assert property (@(posedge clk) disable iff (rst)
        (q == 3'd0 && cnt_en && !load_en) |=> (code == 3'd3));
    a_r2_one_to_five: assert property (@(posedge clk) disable iff (rst)
        (q == 3'd1 && cnt_en && !load_en) |=> (code == 3'd5));
    a_r2_four_to_seven: assert property (@(posedge clk) disable iff (rst)
        (q == 3'd4 && cnt_en && !load_en) |=> (code == 3'd7));
    // R3 / R6: wrap flag is followed by code 0
    a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
        (wrap && !load_en) |=> (code == 3'd0));
    // R5: recovery from the unused code
    a_r5_unused_recovers: assert property (@(posedge clk) disable iff (rst)
        (q == 3'd6 && cnt_en && !load_en) |=> (code == 3'd0));
    // R7 / R5: code 6 only reachable through a load (or held after one)
    a_r7_six_only_loaded: assert property (@(posedge clk) disable iff (rst)
        (!load_en && !(q == 3'd6 && !cnt_en)) |=> (code != 3'd6));

endmodule

// File: tb/custom_seq_counter_tb.sv
module custom_seq_counter_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cnt_en = 1'b0;
    logic       load_en = 1'b0;
    logic [2:0] load_code = 3'd0;
    logic [2:0] code;
    logic       wrap;

    int checks = 0;
    int errors = 0;
    int exp_code = 0;
    int order[$] = '{0, 3, 2, 1, 5, 4, 7};

    always #2 clk = ~clk;

    custom_seq_counter u_dut (
        .clk       (clk),
        .rst       (rst),
        .cnt_en    (cnt_en),
        .load_en   (load_en),
        .load_code (load_code),
        .code      (code),
        .wrap      (wrap)
    );

    function automatic int ref_next(int cur);
        int idx[$];
        idx = order.find_first_index(x) with (x == cur);
        if (idx.size() == 0) return 0;
        return order[(idx[0] + 1) % order.size()];
    endfunction

    task automatic cyc(input logic r, input logic e, input logic l, input int v);
        string tag;
        int    nxt;
        logic  exp_wrap;
        rst = r; cnt_en = e; load_en = l; load_code = 3'(v);
        #1;
        if (!r) begin
            exp_wrap = e && (exp_code == 7);
            checks++;
            if (wrap !== exp_wrap) begin
                errors++;
                $display("FAIL R6 wrap actual=%0b expected=%0b code=%0d", wrap, exp_wrap, exp_code);
            end
        end
        if (r && l)      begin tag = "R8"; nxt = 0; end
        else if (r)      begin tag = "R1"; nxt = 0; end
        else if (l)      begin tag = "R7"; nxt = v; end
        else if (!e)     begin tag = "R4"; nxt = exp_code; end
        else if (exp_code == 7) begin tag = "R3"; nxt = 0; end
        else if (exp_code == 6) begin tag = "R5"; nxt = 0; end
        else             begin tag = "R2"; nxt = ref_next(exp_code); end
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (code !== 3'(nxt)) begin
            errors++;
            $display("FAIL %s code actual=%0d expected=%0d", tag, code, nxt);
        end
        exp_code = nxt;
    endtask

    initial begin
        @(negedge clk);
        cyc(1, 0, 0, 0);
        cyc(1, 1, 0, 0);
        // R2 R3: three uninterrupted cycles
        for (int i = 0; i < 21; i++) cyc(0, 1, 0, 0);
        // R4: idle gaps mid-cycle
        for (int i = 0; i < 10; i++) cyc(0, (i % 3) != 0, 0, 0);
        // R7 R5: load unused code, hold it, then recover
        cyc(0, 0, 1, 6);
        cyc(0, 0, 0, 0);
        cyc(0, 1, 0, 0);
        cyc(0, 1, 0, 0);
        // R7: load with enable high, then wrap from 7
        cyc(0, 1, 1, 7);
        cyc(0, 1, 0, 0);
        cyc(0, 1, 1, 6);
        cyc(0, 1, 0, 0);
        // R8: reset beats load, and reset beats count
        cyc(0, 1, 1, 5);
        cyc(1, 1, 1, 4);
        for (int i = 0; i < 8; i++) cyc(0, 1, 0, 0);
        cyc(1, 1, 0, 0);
        cyc(0, 0, 0, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule